// File: doc/BRIEF.md
# Video control pipeline alignment unit

This block keeps the control strobes of a video stream in step with a pixel datapath whose latency is fixed at fourteen clocks. Pass enable, a spare side-band bit, active video, sync and blank each travel through their own shift-register delay. Several of those delays can be shortened by a static configuration bit, so downstream parts that expect an earlier strobe can be served.

The pixel word travels through the same fourteen-cycle pipeline. At the last stage it is replaced by the black level of the current colour format whenever the active-video bit that travelled with it is low. That bit is not the raw input.

In 4:2:2 operation the block also emits a chroma phase marker beside every output pixel. The marker is set on the first active pixel after a low-to-high change of active video, which makes that pixel a Cb sample. It then alternates on every clock.

Top module: `vid_ctl_align`

## Requirements
- R1: `o_pass_en` and `o_spare` repeat `i_pass_en` and `i_spare` exactly 14 clock cycles later.
- R2: `o_av` repeats `i_av` 14 cycles later when `i_av_short` is 0, and 12 cycles later when `i_av_short` is 1.
- R3: `o_sync` and `o_blank` repeat `i_sync` and `i_blank` 2 cycles later when `i_dac_long` is 0, and 15 cycles later when `i_dac_long` is 1.
- R4: `o_pix` equals the `i_pix` value applied 14 cycles earlier whenever `i_av` was high in that same cycle. The word layout is bits [23:16] = G/Y, bits [15:8] = B/Cb, bits [7:0] = R/Cr.
- R5: If `i_av` was low 14 cycles earlier and `i_fmt_ycc` is 0 (RGB), `o_pix` is 0x000000.
- R6: If `i_av` was low 14 cycles earlier, `i_fmt_ycc` is 1 and `i_twos` is 0 (offset binary), `o_pix` is 0x108080.
- R7: If `i_av` was low 14 cycles earlier, `i_fmt_ycc` is 1 and `i_twos` is 1 (two's complement), `o_pix` is 0x100000.
- R8: With `i_mode422` high, `o_cb_phase` is 1 on the output pixel that follows a low-to-high change of the aligned active video. Otherwise `o_cb_phase` inverts on every clock. With `i_mode422` low, it is 0.
- R9: While `rst` is high at a clock edge, every output is cleared to zero and every delay stage is emptied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| i_pass_en | input | 1 | Pass enable strobe |
| i_spare | input | 1 | Spare side-band bit |
| i_av | input | 1 | Active video |
| i_sync | input | 1 | Sync for the converter |
| i_blank | input | 1 | Blank for the converter |
| i_pix | input | 24 | Pixel word, three 8-bit components |
| i_fmt_ycc | input | 1 | 1 = YCbCr, 0 = RGB |
| i_twos | input | 1 | 1 = two's complement chroma, 0 = offset binary |
| i_mode422 | input | 1 | 4:2:2 chroma phase tracking enable |
| i_av_short | input | 1 | 1 = 12-cycle active-video delay |
| i_dac_long | input | 1 | 1 = 15-cycle sync/blank delay |
| o_pass_en | output | 1 | Delayed pass enable |
| o_spare | output | 1 | Delayed spare bit |
| o_av | output | 1 | Delayed active video |
| o_sync | output | 1 | Delayed sync |
| o_blank | output | 1 | Delayed blank |
| o_pix | output | 24 | Aligned pixel, black when inactive |
| o_cb_phase | output | 1 | 1 when the output pixel is a Cb sample |

## Verification
A stage lost or added in any delay line shows at the ports as a strobe arriving one cycle early or late. The bench measures each strobe's arrival cycle after a single-cycle pulse, so such an error is exposed within 16 cycles. A wrongly aligned active-video bit at the blanking stage blacks out pixels at the wrong cycles, and a wrong black constant appears on the very first inactive pixel. A chroma phase that fails to restart is caught on the first rising edge of active video that arrives at an odd distance from the previous one.

// File: rtl/vca_pkg.sv
package vca_pkg;

   typedef enum logic [1:0] {
      BLK_RGB     = 2'd0,
      BLK_YCC_OFS = 2'd1,
      BLK_YCC_2C  = 2'd2
   } blk_kind_e;

   function automatic blk_kind_e blk_kind(input logic ycc, input logic twos);
      if (!ycc)
         return BLK_RGB;
      if (twos)
         return BLK_YCC_2C;
      return BLK_YCC_OFS;
   endfunction

endpackage

// File: rtl/vca_delay_line.sv
module vca_delay_line #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("vca_delay_line: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("vca_delay_line: WIDTH must be at least 1");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [WIDTH-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (rst)
               stage_q <= '0;
            else
               stage_q <= din;
         end
         assign dout = stage_q;
      end else begin : g_chain
         logic [DEPTH-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (rst)
               stage_q <= '0;
            else
               stage_q <= {stage_q[DEPTH-2:0], din};
         end
         assign dout = stage_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/vca_tap_delay.sv
module vca_tap_delay #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned SHORT = 2,
   parameter int unsigned LONG  = 15
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   input  logic             sel_long,
   output logic [WIDTH-1:0] dout
);

   localparam int unsigned EXTRA = LONG - SHORT;

   if (SHORT < 1 || LONG <= SHORT) begin : g_bad_taps
      $error("vca_tap_delay: need 1 <= SHORT < LONG");
   end

   logic [WIDTH-1:0] near_tap;
   logic [WIDTH-1:0] far_tap;

   vca_delay_line #(.WIDTH(WIDTH), .DEPTH(SHORT)) near_i (
      .clk (clk),
      .rst (rst),
      .din (din),
      .dout(near_tap)
   );

   vca_delay_line #(.WIDTH(WIDTH), .DEPTH(EXTRA)) far_i (
      .clk (clk),
      .rst (rst),
      .din (near_tap),
      .dout(far_tap)
   );

   assign dout = sel_long ? far_tap : near_tap;

endmodule

// File: rtl/vca_blanker.sv
module vca_blanker
   import vca_pkg::*;
#(
   parameter int unsigned COMP_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [3*COMP_W-1:0] pix_al,
   input  logic                av_al,
   input  logic                fmt_ycc,
   input  logic                twos,
   input  logic                mode422,
   output logic [3*COMP_W-1:0] pix_q,
   output logic                phase_q
);

   localparam int unsigned        SHIFT   = COMP_W - 8;
   localparam logic [COMP_W-1:0] Y_BLACK = COMP_W'(8'h10) << SHIFT;
   localparam logic [COMP_W-1:0] C_MID   = COMP_W'(8'h80) << SHIFT;

   if (COMP_W < 8) begin : g_bad_comp
      $error("vca_blanker: COMP_W must be at least 8");
   end

   blk_kind_e           kind;
   logic [3*COMP_W-1:0] blk_word;
   logic                av_prev_q;
   logic                av_rise;

   assign kind = blk_kind(fmt_ycc, twos);

   always_comb begin
      case (kind)
         BLK_YCC_OFS: blk_word = {Y_BLACK, C_MID, C_MID};
         BLK_YCC_2C:  blk_word = {Y_BLACK, {COMP_W{1'b0}}, {COMP_W{1'b0}}};
         default:     blk_word = '0;
      endcase
   end

   assign av_rise = av_al & ~av_prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pix_q     <= '0;
         phase_q   <= 1'b0;
         av_prev_q <= 1'b0;
      end else begin
         pix_q     <= av_al ? pix_al : blk_word;
         av_prev_q <= av_al;
         if (!mode422)
            phase_q <= 1'b0;
         else if (av_rise)
            phase_q <= 1'b1;
         else
            phase_q <= ~phase_q;
      end
   end

   AST_PIX_PASS: assert property (@(posedge clk) disable iff (rst)
      av_al |=> pix_q == $past(pix_al)) else $error("pixel not passed"); // R4
   AST_BLACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
      !av_al |=> pix_q == $past(blk_word)) else $error("black level wrong"); // R5
   AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
      (mode422 && av_rise) |=> phase_q) else $error("phase not restarted"); // R8
   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      (mode422 && !av_rise) |=> phase_q != $past(phase_q)) else $error("phase stuck"); // R8
   AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !mode422 |=> !phase_q) else $error("phase active outside 4:2:2"); // R8

endmodule

// File: rtl/vid_ctl_align.sv
module vid_ctl_align #(
   parameter int unsigned COMP_W    = 8,
   parameter int unsigned PIX_LAT   = 14,
   parameter int unsigned AV_SHORT  = 12,
   parameter int unsigned DAC_SHORT = 2,
   parameter int unsigned DAC_LONG  = 15
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                i_pass_en,
   input  logic                i_spare,
   input  logic                i_av,
   input  logic                i_sync,
   input  logic                i_blank,
   input  logic [3*COMP_W-1:0] i_pix,
   input  logic                i_fmt_ycc,
   input  logic                i_twos,
   input  logic                i_mode422,
   input  logic                i_av_short,
   input  logic                i_dac_long,
   output logic                o_pass_en,
   output logic                o_spare,
   output logic                o_av,
   output logic                o_sync,
   output logic                o_blank,
   output logic [3*COMP_W-1:0] o_pix,
   output logic                o_cb_phase
);

   localparam int unsigned PIX_W   = 3 * COMP_W;
   localparam int unsigned PRE_LAT = PIX_LAT - 1;

   if (PIX_LAT < 2) begin : g_bad_lat
      $error("vid_ctl_align: PIX_LAT must be at least 2");
   end
   if (AV_SHORT >= PIX_LAT) begin : g_bad_av
      $error("vid_ctl_align: AV_SHORT must be below PIX_LAT");
   end

   logic [PIX_W:0] pre_in;
   logic [PIX_W:0] pre_out;
   logic [1:0]     side_out;
   logic [1:0]     dac_out;
   logic           av_dly;

   assign pre_in = {i_av, i_pix};

   vca_delay_line #(.WIDTH(PIX_W + 1), .DEPTH(PRE_LAT)) pix_line_i (
      .clk (clk),
      .rst (rst),
      .din (pre_in),
      .dout(pre_out)
   );

   vca_blanker #(.COMP_W(COMP_W)) blank_i (
      .clk    (clk),
      .rst    (rst),
      .pix_al (pre_out[PIX_W-1:0]),
      .av_al  (pre_out[PIX_W]),
      .fmt_ycc(i_fmt_ycc),
      .twos   (i_twos),
      .mode422(i_mode422),
      .pix_q  (o_pix),
      .phase_q(o_cb_phase)
   );

   vca_delay_line #(.WIDTH(2), .DEPTH(PIX_LAT)) side_line_i (
      .clk (clk),
      .rst (rst),
      .din ({i_pass_en, i_spare}),
      .dout(side_out)
   );

   vca_tap_delay #(.WIDTH(1), .SHORT(AV_SHORT), .LONG(PIX_LAT)) av_line_i (
      .clk     (clk),
      .rst     (rst),
      .din     (i_av),
      .sel_long(~i_av_short),
      .dout    (av_dly)
   );

   vca_tap_delay #(.WIDTH(2), .SHORT(DAC_SHORT), .LONG(DAC_LONG)) dac_line_i (
      .clk     (clk),
      .rst     (rst),
      .din     ({i_sync, i_blank}),
      .sel_long(i_dac_long),
      .dout    (dac_out)
   );

   assign o_pass_en = side_out[1];
   assign o_spare   = side_out[0];
   assign o_av      = av_dly;
   assign o_sync    = dac_out[1];
   assign o_blank   = dac_out[0];

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (o_pix == '0 && !o_cb_phase && !o_pass_en && !o_spare)) else $error("reset left state"); // R9
   AST_AV_ALIGN: assert property (@(posedge clk) disable iff (rst)
      (!i_av_short && $past(!i_av_short)) |-> o_av == blank_i.av_prev_q) else $error("av misaligned"); // R2

endmodule

// File: tb/vid_ctl_align_tb_top.sv
`timescale 1ns/100ps
module vid_ctl_align_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        i_pass_en, i_spare, i_av, i_sync, i_blank;
   logic [23:0] i_pix;
   logic        i_fmt_ycc, i_twos, i_mode422, i_av_short, i_dac_long;
   logic        o_pass_en, o_spare, o_av, o_sync, o_blank, o_cb_phase;
   logic [23:0] o_pix;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   vid_ctl_align dut_i (
      .clk(clk), .rst(rst),
      .i_pass_en(i_pass_en), .i_spare(i_spare), .i_av(i_av),
      .i_sync(i_sync), .i_blank(i_blank), .i_pix(i_pix),
      .i_fmt_ycc(i_fmt_ycc), .i_twos(i_twos), .i_mode422(i_mode422),
      .i_av_short(i_av_short), .i_dac_long(i_dac_long),
      .o_pass_en(o_pass_en), .o_spare(o_spare), .o_av(o_av),
      .o_sync(o_sync), .o_blank(o_blank), .o_pix(o_pix),
      .o_cb_phase(o_cb_phase)
   );

   typedef struct packed {
      logic        av;
      logic        ycc;
      logic        twos;
      logic [23:0] pix;
      logic [23:0] expv;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b0, 1'b0, 24'hA1B2C3, 24'hA1B2C3},   // R4
      '{1'b0, 1'b0, 1'b0, 24'hA1B2C3, 24'h000000},   // R5
      '{1'b0, 1'b1, 1'b0, 24'h445566, 24'h108080},   // R6
      '{1'b0, 1'b1, 1'b1, 24'h445566, 24'h100000},   // R7
      '{1'b1, 1'b1, 1'b1, 24'h5A3C7E, 24'h5A3C7E},   // R4
      '{1'b0, 1'b0, 1'b1, 24'hFFFFFF, 24'h000000},   // R5
      '{1'b1, 1'b1, 1'b0, 24'h010203, 24'h010203}    // R4
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic probe(input int sel);
      case (sel)
         0: return o_pass_en;
         1: return o_spare;
         2: return o_av;
         3: return o_sync;
         default: return o_blank;
      endcase
   endfunction

   task automatic drive(input int sel, input logic v);
      case (sel)
         0: i_pass_en = v;
         1: i_spare   = v;
         2: i_av      = v;
         3: i_sync    = v;
         default: i_blank = v;
      endcase
   endtask

   // one-cycle pulse; returns the number of edges until the output shows it
   task automatic latency(input int sel, output int n);
      n = -1;
      @(negedge clk);
      drive(sel, 1'b1);
      for (int c = 1; c <= 40; c++) begin
         @(negedge clk);
         if (c == 1) drive(sel, 1'b0);
         if (probe(sel) && n < 0) n = c;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      rst = 1'b1;
      i_pass_en = 1'b1; i_spare = 1'b1; i_av = 1'b1; i_sync = 1'b1; i_blank = 1'b1;
      i_pix = 24'hFFFFFF; i_fmt_ycc = 1'b1; i_twos = 1'b0; i_mode422 = 1'b1;
      i_av_short = 1'b0; i_dac_long = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: all outputs zero under reset even with inputs high
      check("R9 reset",
            {8'd0, o_pix},
            32'd0);
      check("R9 reset ctl",
            {26'd0, o_pass_en, o_spare, o_av, o_sync, o_blank, o_cb_phase},
            32'd0);
      i_pass_en = 1'b0; i_spare = 1'b0; i_av = 1'b0; i_sync = 1'b0; i_blank = 1'b0;
      i_mode422 = 1'b0;
      rst = 1'b0;

      // vector table: pixel pass and black levels
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         i_av = VEC[v].av; i_fmt_ycc = VEC[v].ycc; i_twos = VEC[v].twos; i_pix = VEC[v].pix;
         repeat (16) @(negedge clk);
         check(VEC[v].av ? "R4 pass" : (VEC[v].ycc ? (VEC[v].twos ? "R7 black" : "R6 black") : "R5 black"),
               {8'd0, o_pix}, {8'd0, VEC[v].expv});
      end
      i_av = 1'b0;
      repeat (20) @(negedge clk);

      // R1 pass and spare latency
      latency(0, n); check("R1 pass_en", n, 14);
      latency(1, n); check("R1 spare", n, 14);
      // R2 active video latency, both settings
      i_av_short = 1'b0;
      latency(2, n); check("R2 av long", n, 14);
      i_av_short = 1'b1;
      latency(2, n); check("R2 av short", n, 12);
      i_av_short = 1'b0;
      // R3 sync and blank latency, both settings
      i_dac_long = 1'b0;
      latency(3, n); check("R3 sync short", n, 2);
      latency(4, n); check("R3 blank short", n, 2);
      i_dac_long = 1'b1;
      latency(3, n); check("R3 sync long", n, 15);
      latency(4, n); check("R3 blank long", n, 15);
      i_dac_long = 1'b0;

      // R8: chroma phase restart in 4:2:2 mode, plus R4 gap blanking
      i_fmt_ycc = 1'b0; i_twos = 1'b0; i_pix = 24'h123456; i_av = 1'b0;
      i_mode422 = 1'b1;
      repeat (20) @(negedge clk);
      i_av = 1'b1;
      for (int c = 1; c <= 24; c++) begin
         @(negedge clk);
         if (c == 14) check("R8 first Cb", o_cb_phase, 1);
         if (c == 14) check("R4 first active pixel", {8'd0, o_pix}, 32'h123456);
         if (c == 15) check("R8 toggle to Cr", o_cb_phase, 0);
         if (c == 16) check("R8 toggle to Cb", o_cb_phase, 1);
         if (c == 19) check("R5 gap pixel black", {8'd0, o_pix}, 32'd0);
         if (c == 21) check("R8 restart odd distance", o_cb_phase, 1);
         if (c == 22) check("R8 after restart", o_cb_phase, 0);
         if (c == 5) i_av = 1'b0;
         if (c == 7) i_av = 1'b1;
      end
      i_mode422 = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 idle outside 4:2:2", o_cb_phase, 0);
      @(negedge clk);
      check("R8 idle outside 4:2:2 next", o_cb_phase, 0);

      // R9: reset mid-stream empties the delay lines
      i_pass_en = 1'b1;
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      i_pass_en = 1'b0;
      rst = 1'b0;
      for (int c = 1; c <= 16; c++) begin
         @(negedge clk);
         if (o_pass_en) begin
            check("R9 flushed line", o_pass_en, 0);
            break;
         end
      end
      check("R9 flushed end", o_pass_en, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule